// File: doc/BRIEF.md
# SAR Conversion Sequencing Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. When it is selected and told to convert, it first holds the sampling phase for a fixed number of clock cycles. It then runs a binary search over the result bits. During the search it drives a trial code to an external capacitive DAC and reads back one comparator decision for each bit.

When the last bit has been decided, the result and the channel address taken at the start are written together into one output word. That word stays unchanged until the next conversion completes. A busy flag covers the whole conversion, and a one-cycle done pulse marks the moment the output word updates.

The analog front end is outside the block: the sample-and-hold, the comparator, the DAC and the reference. The comparator input `cmpHigh` must be high when the trial code on `dacCode` is greater than the sampled input.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion starts only on a clock edge where the block is idle and both `chipSel` and `convStart` are high; either one alone leaves `busy` low.
- R2: The search register is cleared when a conversion starts, so `dacCode` reads zero throughout the acquire phase.
- R3: While a conversion is in progress, `convStart` and `chipSel` have no effect: neither the latency nor the result changes.
- R4: Bits are resolved from the most significant to the least significant, two cycles per bit. In the first cycle the trial bit is set on `dacCode`. On the next edge that bit is cleared if `cmpHigh` is high and kept otherwise. With an ideal comparator the result is the input value, saturated at 2^RES_BITS-1.
- R5: The acquire phase lasts ACQ_CYCLES clock cycles after the start edge. The MSB trial code (only bit RES_BITS-1 set) appears on `dacCode` in the cycle after that.
- R6: `outWord` holds the captured address in bits [RES_BITS+ADDR_BITS-1:RES_BITS] (15:12 by default) and the result in bits [RES_BITS-1:0] (11:0 by default). It changes only when a conversion completes.
- R7: `done` is high for exactly one cycle, ACQ_CYCLES+2*RES_BITS+1 clock edges after the start edge, in the cycle where `outWord` first shows the new result. `busy` is high from the cycle after the start edge up to that cycle and low in it.
- R8: `chanAddr` is sampled on the start edge; later changes do not alter the word that is loaded.
- R9: While `rstN` is low at a clock edge, the block returns to idle with `outWord`, `dacCode`, `busy` and `done` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| chipSel | input | 1 | Block select, active high |
| convStart | input | 1 | Conversion request, active high |
| chanAddr | input | ADDR_BITS (4) | Channel address stored with the result |
| cmpHigh | input | 1 | Comparator: trial code is above the input |
| dacCode | output | RES_BITS (12) | Trial code for the capacitive DAC |
| outWord | output | ADDR_BITS+RES_BITS (16) | Latched address and result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `outWord` updates |

## Verification
The bench uses the default 12-bit result, 4-bit address and 30 acquire cycles; at the 200 MHz bench clock, 30 cycles are 150 ns. Because the result is only 12 bits wide, a stepped sweep across the whole input range can run, with the end values and an over-range input added. Each conversion is checked cycle by cycle against the arithmetic latency and against the trial-code schedule. Every fifth conversion holds the start request high and flips the address while busy, to show that a running conversion cannot be disturbed.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef struct packed {
    logic clearSar;
    logic captureAddr;
    logic setTrial;
    logic decide;
    logic loadOut;
  } sarStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SET,
    ST_DECIDE,
    ST_LOAD
  } sarState_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int ACQ_CYCLES = 30,
  localparam int IDX_W     = (RES_BITS > 1) ? $clog2(RES_BITS) : 1,
  localparam int ACQ_W     = $clog2(ACQ_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              convStart,
  output sarStrobes_t       stb,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              busy,
  output logic              done
);

  localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(RES_BITS - 1);
  localparam logic [ACQ_W-1:0] ACQ_LAST = ACQ_W'(ACQ_CYCLES - 1);

  sarState_t        state;
  logic [ACQ_W-1:0] acqCnt;
  logic             startEvt;

  assign startEvt = (state == ST_IDLE) && chipSel && convStart;

  always_comb begin
    stb.clearSar    = startEvt;
    stb.captureAddr = startEvt;
    stb.setTrial    = (state == ST_SET);
    stb.decide      = (state == ST_DECIDE);
    stb.loadOut     = (state == ST_LOAD);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      acqCnt <= '0;
      bitIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= (state == ST_LOAD);
      case (state)
        ST_IDLE: begin
          if (startEvt) begin
            state  <= ST_ACQ;
            acqCnt <= '0;
          end
        end
        ST_ACQ: begin
          if (acqCnt == ACQ_LAST) begin
            state  <= ST_SET;
            bitIdx <= MSB_IDX;
          end else begin
            acqCnt <= acqCnt + 1'b1;
          end
        end
        ST_SET: state <= ST_DECIDE;
        ST_DECIDE: begin
          if (bitIdx == '0) begin
            state <= ST_LOAD;
          end else begin
            bitIdx <= bitIdx - 1'b1;
            state  <= ST_SET;
          end
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent count of acquire cycles, used only by the checks below
  logic [ACQ_W-1:0] acqSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                 acqSeen <= '0;
    else if (startEvt)         acqSeen <= '0;
    else if (state == ST_ACQ && acqSeen != {ACQ_W{1'b1}}) acqSeen <= acqSeen + 1'b1;
  end

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(chipSel && convStart)); // R1
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SET && $past(state) == ST_ACQ) |-> (bitIdx == MSB_IDX)); // R4
  AST_BIT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SET && $past(state) == ST_DECIDE) |-> (bitIdx == $past(bitIdx) - 1'b1)); // R4
  AST_ACQ_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SET && $past(state) == ST_ACQ) |-> (acqSeen == ACQ_W'(ACQ_CYCLES))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int ADDR_BITS = 4,
  localparam int IDX_W    = (RES_BITS > 1) ? $clog2(RES_BITS) : 1,
  localparam int WORD_W   = RES_BITS + ADDR_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sarStrobes_t          stb,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic                 busy,
  input  logic                 cmpHigh,
  input  logic [ADDR_BITS-1:0] chanAddr,
  output logic [RES_BITS-1:0]  dacCode,
  output logic [WORD_W-1:0]    outWord
);

  logic [RES_BITS-1:0]  sarQ;
  logic [ADDR_BITS-1:0] addrHold;

  for (genvar i = 0; i < RES_BITS; i++) begin : g_sarBit
    logic bitQ;
    logic hit;
    assign hit = (bitIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)                   bitQ <= 1'b0;
      else if (stb.clearSar)       bitQ <= 1'b0;
      else if (stb.setTrial && hit) bitQ <= 1'b1;
      else if (stb.decide && hit)   bitQ <= ~cmpHigh;
    end
    assign sarQ[i] = bitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      outWord  <= '0;
    end else begin
      if (stb.captureAddr) addrHold <= chanAddr;
      if (stb.loadOut)     outWord  <= {addrHold, sarQ};
    end
  end

  assign dacCode = sarQ;

  AST_SAR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearSar |=> (sarQ == '0)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.clearSar); // R3
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> $stable(outWord)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrHold)); // R8

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int ADDR_BITS  = 4,
  parameter int ACQ_CYCLES = 30,
  localparam int IDX_W     = (RES_BITS > 1) ? $clog2(RES_BITS) : 1,
  localparam int WORD_W    = RES_BITS + ADDR_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chipSel,
  input  logic                 convStart,
  input  logic [ADDR_BITS-1:0] chanAddr,
  input  logic                 cmpHigh,
  output logic [RES_BITS-1:0]  dacCode,
  output logic [WORD_W-1:0]    outWord,
  output logic                 busy,
  output logic                 done
);

  sarStrobes_t      stb;
  logic [IDX_W-1:0] bitIdx;

  sar_seq_ctrl #(
    .RES_BITS  (RES_BITS),
    .ACQ_CYCLES(ACQ_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .convStart(convStart),
    .stb      (stb),
    .bitIdx   (bitIdx),
    .busy     (busy),
    .done     (done)
  );

  sar_seq_datapath #(
    .RES_BITS (RES_BITS),
    .ADDR_BITS(ADDR_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bitIdx  (bitIdx),
    .busy    (busy),
    .cmpHigh (cmpHigh),
    .chanAddr(chanAddr),
    .dacCode (dacCode),
    .outWord (outWord)
  );

endmodule

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
  localparam int N   = 12;
  localparam int A   = 4;
  localparam int ACQ = 30;
  localparam int LAT = ACQ + 2 * N + 1;
  localparam int MAXV = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         chipSel = 1'b0;
  logic         convStart = 1'b0;
  logic [A-1:0] chanAddr = '0;
  logic         cmpHigh;
  logic [N-1:0] dacCode;
  logic [N+A-1:0] outWord;
  logic         busy;
  logic         done;
  int           vin = 0;
  int           checks = 0;
  int           failures = 0;

  always #2.5 clk = ~clk;

  // ideal comparator: high when the trial code is above the input
  assign cmpHigh = (int'(dacCode) > vin);

  sar_seq_top #(.RES_BITS(N), .ADDR_BITS(A), .ACQ_CYCLES(ACQ)) dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .convStart(convStart),
    .chanAddr(chanAddr), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .outWord(outWord), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doConvert(input int v, input logic [A-1:0] ad, input bit noisy);
    int  n;
    bit  gotDone;
    bit  acqZero;
    bit  busyOk;
    bit  msbOk;
    int  expRes;
    logic [N+A-1:0] expWord;
    expRes  = (v > MAXV) ? MAXV : v;
    expWord = {ad, N'(expRes)};
    @(negedge clk);
    vin = v; chanAddr = ad; chipSel = 1'b1; convStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (noisy) chanAddr = ~ad;
    else begin chipSel = 1'b0; convStart = 1'b0; end
    n = 0; gotDone = 0; acqZero = 1; busyOk = 1; msbOk = 1;
    while (!gotDone && n < LAT + 5) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (noisy) begin chanAddr = ~chanAddr; convStart = ~convStart | (n < 3); end
      if (done) begin
        gotDone = 1;
        chipSel = 1'b0; convStart = 1'b0;
      end
      if (n <= ACQ && dacCode != '0) acqZero = 0;
      if (n == ACQ + 1 && dacCode != N'(1 << (N - 1))) msbOk = 0;
      if ((n < LAT) != busy) busyOk = 0;
    end
    chk(n == LAT, "R7 latency", n, LAT);
    chk(busyOk, "R7 busy window", busyOk, 1);
    chk(acqZero, "R2 R5 dacCode zero during acquire", acqZero, 1);
    chk(msbOk, "R4 R5 MSB trial after acquire", msbOk, 1);
    chk(outWord == expWord, noisy ? "R3 R8 R6 R4 word under disturbance" : "R4 R6 word",
        outWord, expWord);
    @(negedge clk);
    chk(!done && outWord == expWord && !busy, "R6 R7 word held, done single", outWord, expWord);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R7 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outWord == '0 && dacCode == '0 && !busy && !done, "R9 reset state", outWord, 0);
    rstN = 1'b1;

    // R1: either qualifier alone never starts
    @(negedge clk); chipSel = 1'b0; convStart = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done, "R1 convStart without chipSel", busy, 0);
    chipSel = 1'b1; convStart = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !done, "R1 chipSel without convStart", busy, 0);
    chipSel = 1'b0;

    // boundary values
    doConvert(0, 4'h0, 0);
    doConvert(1, 4'hF, 0);
    doConvert(MAXV / 2, 4'h5, 0);
    doConvert(MAXV / 2 + 1, 4'hA, 1);
    doConvert(MAXV - 1, 4'h3, 0);
    doConvert(MAXV, 4'hC, 1);
    doConvert(MAXV + 1000, 4'h7, 0);

    // stepped sweep over the range
    for (int k = 0; k * 13 <= MAXV; k++) begin
      doConvert(k * 13, A'(k), (k % 5) == 0);
    end

    // R9: reset after a conversion clears the latch
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(outWord == '0 && !busy && !done && dacCode == '0, "R9 reset clears latch", outWord, 0);
    rstN = 1'b1;
    doConvert(1234, 4'h9, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule